// File: doc/BRIEF.md
# Hierarchical JTAG Test Access Port with Debug Handoff

This block is the top-level IEEE 1149.1 test access port controller. It contains the 16-state TAP state machine, a 4-bit instruction register with its decoder, and the data register path. The data register path selects one of three registers: a 32-bit identification register, a 1-bit bypass register, or an external boundary-scan chain. The chain is reached through capture, shift and update strobes, a serial input and a serial output. The boundary-scan cells are outside the block.

One public instruction hands the port over to a secondary debug TAP, which shares the clock, TMS and TDI pins. Once that instruction takes effect, the top-level controller parks in Run-Test/Idle whatever TMS does, and the pin TDO carries the secondary TAP's TDO. Only the asynchronous test reset ends the handoff.

Instruction encodings:

| Code | Instruction | Data register |
|------|-------------|---------------|
| 0x0 | EXTEST | boundary-scan chain |
| 0x1 | IDCODE | identification register |
| 0x2 | SAMPLE/PRELOAD | boundary-scan chain |
| 0x3 | debug handoff | (bypass) |
| 0x8 | CLAMP | bypass |
| 0xF | BYPASS | bypass |

Every other code behaves like BYPASS.

Top module: `jtag_handoff_tap`

## Requirements
- R1: Driving rst_ni low asynchronously forces Test-Logic-Reset, loads IDCODE (0x1), ends any handoff and drops tdo_oe_o and bsr_drive_o.
- R2: When the port is not handed off, five rising tck_i edges with tms_i high reach Test-Logic-Reset from any state, and the instruction returns to IDCODE.
- R3: In Capture-IR the instruction shift register loads binary 0001. Shift-IR then presents it on tdo_o least significant bit first, so the sequence is 1,0,0,0.
- R4: The active instruction changes only on the falling tck_i edge in Update-IR. A new code shifted in has no effect on any output while the controller is in Exit1-IR.
- R5: With IDCODE active, Capture-DR loads the 32-bit identification value with bit 0 forced to 1. Shift-DR then presents it on tdo_o least significant bit first.
- R6: BYPASS (0xF), CLAMP (0x8) and every unused code select a 1-bit register. That register captures 0 and shifts tdi_i through with a delay of one clock.
- R7: The strobes bsr_capture_o and bsr_shift_o are high in Capture-DR and Shift-DR respectively, and only when EXTEST (0x0) or SAMPLE/PRELOAD (0x2) is active. In Shift-DR, tdo_o then carries bsr_so_i.
- R8: For EXTEST or SAMPLE/PRELOAD, bsr_update_o rises on the falling tck_i edge in Update-DR and falls on the next falling edge.
- R9: bsr_drive_o is high only while EXTEST (0x0) or CLAMP (0x8) is active.
- R10: tdo_o changes on the falling tck_i edge. tdo_oe_o is high only after a falling edge taken in Shift-IR or Shift-DR, or during a handoff.
- R11: Code 0x3 taking effect in Update-IR raises sec_sel_o. From then on tdo_o follows sec_tdo_i with tdo_oe_o high, the controller stays in Run-Test/Idle whatever tms_i does, and no boundary-scan strobe fires until rst_ni is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Test data in |
| tdo_o | output | 1 | Test data out |
| tdo_oe_o | output | 1 | Output enable for the TDO pin driver |
| bsr_capture_o | output | 1 | Boundary-scan capture strobe |
| bsr_shift_o | output | 1 | Boundary-scan shift strobe |
| bsr_update_o | output | 1 | Boundary-scan update strobe, falling-edge timed |
| bsr_drive_o | output | 1 | Update cells drive the pins (EXTEST or CLAMP) |
| bsr_si_o | output | 1 | Serial data toward the chain |
| bsr_so_i | input | 1 | Serial data from the chain |
| sec_sel_o | output | 1 | Port handed to the secondary TAP |
| sec_tdo_i | input | 1 | TDO of the secondary TAP |

## Verification
The assertions assume that rst_ni is asserted once before the first tck_i edge, so the state and instruction never hold unknown values. They also assume that tms_i and tdi_i settle well before each rising edge. The bench meets these assumptions by holding reset at start-up. It changes tms_i, tdi_i, bsr_so_i and sec_tdo_i only a nanosecond after a falling edge, and it samples outputs there as well, away from both clock edges.

// File: rtl/jtag_handoff_pkg.sv
package jtag_handoff_pkg;
  localparam int unsigned IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
    ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] IR_EXTEST  = 4'h0;
  localparam logic [IR_W-1:0] IR_IDCODE  = 4'h1;
  localparam logic [IR_W-1:0] IR_SAMPLE  = 4'h2;
  localparam logic [IR_W-1:0] IR_HANDOFF = 4'h3;
  localparam logic [IR_W-1:0] IR_CLAMP   = 4'h8;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    unique case (s)
      ST_TLR:    return tms ? ST_TLR    : ST_RTI;
      ST_RTI:    return tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: return tms ? ST_SEL_DR : ST_RTI;
      default:   return ST_TLR;
    endcase
  endfunction
endpackage

// File: rtl/jtag_handoff_fsm.sv
module jtag_handoff_fsm
  import jtag_handoff_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  input  logic       park_i,
  output tap_state_e state_o
);
  tap_state_e state_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= ST_TLR;
    else if (park_i) state_q <= ST_RTI;  // frozen while handed off
    else             state_q <= tap_next(state_q, tms_i);
  end

  assign state_o = state_q;
endmodule

// File: rtl/jtag_handoff_ir.sv
module jtag_handoff_ir
  import jtag_handoff_pkg::*;
#(
  parameter int unsigned     W          = IR_W,
  parameter logic [W-1:0]    CAP_VAL    = W'(1),
  parameter logic [W-1:0]    RESET_CODE = W'(1)
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  tap_state_e   state_i,
  input  logic         tdi_i,
  output logic [W-1:0] ir_o,
  output logic         so_o
);
  logic [W-1:0] sr_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                   sr_q <= CAP_VAL;
    else if (state_i == ST_CAP_IR) sr_q <= CAP_VAL;
    else if (state_i == ST_SH_IR)  sr_q <= {tdi_i, sr_q[W-1:1]};
  end

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                   ir_q <= RESET_CODE;
    else if (state_i == ST_TLR)    ir_q <= RESET_CODE;
    else if (state_i == ST_UPD_IR) ir_q <= sr_q;
  end

  assign ir_o = ir_q;
  assign so_o = sr_q[0];
endmodule

// File: rtl/jtag_handoff_dr.sv
module jtag_handoff_dr
  import jtag_handoff_pkg::*;
#(
  parameter int unsigned      ID_W   = 32,
  parameter logic [ID_W-1:0]  ID_VAL = 32'h0B5E_A01D
) (
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  logic       tdi_i,
  input  logic       sel_id_i,
  input  logic       sel_bsr_i,
  input  logic       bsr_so_i,
  output logic       so_o
);
  localparam logic [ID_W-1:0] ID_CAP = ID_VAL | ID_W'(1);

  logic [ID_W-1:0] id_q;
  logic            byp_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q  <= ID_CAP;
      byp_q <= 1'b0;
    end else begin
      if (sel_id_i && state_i == ST_CAP_DR)     id_q <= ID_CAP;
      else if (sel_id_i && state_i == ST_SH_DR) id_q <= {tdi_i, id_q[ID_W-1:1]};
      if (state_i == ST_CAP_DR)                 byp_q <= 1'b0;
      else if (state_i == ST_SH_DR)             byp_q <= tdi_i;
    end
  end

  always_comb begin
    if (sel_bsr_i)     so_o = bsr_so_i;
    else if (sel_id_i) so_o = id_q[0];
    else               so_o = byp_q;
  end
endmodule

// File: rtl/jtag_handoff_tap.sv
module jtag_handoff_tap
  import jtag_handoff_pkg::*;
#(
  parameter int unsigned     ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VAL = 32'h0B5E_A01D
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tms_i,
  input  logic tdi_i,
  output logic tdo_o,
  output logic tdo_oe_o,
  output logic bsr_capture_o,
  output logic bsr_shift_o,
  output logic bsr_update_o,
  output logic bsr_drive_o,
  output logic bsr_si_o,
  input  logic bsr_so_i,
  output logic sec_sel_o,
  input  logic sec_tdo_i
);
  tap_state_e      state_q;
  logic [IR_W-1:0] ir_q;
  logic            ir_so, dr_so;
  logic            sel_bsr, sel_id, sec_sel;
  logic            tdo_q, oe_q, upd_q;

  assign sec_sel = (ir_q == IR_HANDOFF);
  assign sel_bsr = (ir_q == IR_EXTEST) || (ir_q == IR_SAMPLE);
  assign sel_id  = (ir_q == IR_IDCODE);

  jtag_handoff_fsm u_fsm (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .tms_i  (tms_i),
    .park_i (sec_sel),
    .state_o(state_q)
  );

  jtag_handoff_ir #(.W(IR_W), .CAP_VAL(IR_CAPTURE), .RESET_CODE(IR_IDCODE)) u_ir (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .state_i(state_q),
    .tdi_i  (tdi_i),
    .ir_o   (ir_q),
    .so_o   (ir_so)
  );

  jtag_handoff_dr #(.ID_W(ID_W), .ID_VAL(ID_VAL)) u_dr (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .state_i  (state_q),
    .tdi_i    (tdi_i),
    .sel_id_i (sel_id),
    .sel_bsr_i(sel_bsr),
    .bsr_so_i (bsr_so_i),
    .so_o     (dr_so)
  );

  // falling-edge output stage
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      tdo_q <= (state_q == ST_SH_IR) ? ir_so : dr_so;
      oe_q  <= (state_q == ST_SH_IR) || (state_q == ST_SH_DR);
      upd_q <= sel_bsr && (state_q == ST_UPD_DR);
    end
  end

  assign tdo_o         = sec_sel ? sec_tdo_i : tdo_q;
  assign tdo_oe_o      = sec_sel | oe_q;
  assign bsr_capture_o = sel_bsr && (state_q == ST_CAP_DR);
  assign bsr_shift_o   = sel_bsr && (state_q == ST_SH_DR);
  assign bsr_update_o  = upd_q;
  assign bsr_drive_o   = (ir_q == IR_EXTEST) || (ir_q == IR_CLAMP);
  assign bsr_si_o      = tdi_i;
  assign sec_sel_o     = sec_sel;
endmodule

// File: rtl/jtag_handoff_tap_chk.sv
module jtag_handoff_tap_chk
  import jtag_handoff_pkg::*;
(
  input logic            tck_i,
  input logic            rst_ni,
  input tap_state_e      state_q,
  input logic [IR_W-1:0] ir_q,
  input logic            sec_sel_o,
  input logic            tdo_oe_o,
  input logic            bsr_capture_o,
  input logic            bsr_shift_o,
  input logic            bsr_update_o
);
  logic past_ok_q;
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  p_park_rti_r11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    sec_sel_o |=> (state_q == ST_RTI));

  p_handoff_sticky_r11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    sec_sel_o |=> sec_sel_o);

  p_strobes_excl_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({bsr_capture_o, bsr_shift_o, bsr_update_o}));

  p_tlr_idcode_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_TLR) |-> (ir_q == IR_IDCODE));

  p_oe_window_r10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o |-> (sec_sel_o || state_q == ST_SH_DR || state_q == ST_SH_IR));

  p_ir_update_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (past_ok_q && ir_q != $past(ir_q)) |-> (state_q == ST_UPD_IR || state_q == ST_TLR));
endmodule

bind jtag_handoff_tap jtag_handoff_tap_chk u_chk (
  .tck_i        (tck_i),
  .rst_ni       (rst_ni),
  .state_q      (state_q),
  .ir_q         (ir_q),
  .sec_sel_o    (sec_sel_o),
  .tdo_oe_o     (tdo_oe_o),
  .bsr_capture_o(bsr_capture_o),
  .bsr_shift_o  (bsr_shift_o),
  .bsr_update_o (bsr_update_o)
);

// File: tb/jtag_handoff_tap_bench.sv
`timescale 1ns/1ps
module jtag_handoff_tap_bench;
  localparam logic [31:0] ID_VAL = 32'h0B5E_A01D;
  localparam logic [31:0] ID_EXP = ID_VAL | 32'h1;

  // {code[3:0], exp_bsr_shift, exp_drive, exp_tdo_first, exp_tdo_second}
  localparam int NV = 7;
  localparam logic [7:0] VEC [NV] = '{
    8'b0000_1_1_0_0,  // EXTEST: chain, drive
    8'b0001_0_0_1_0,  // IDCODE: id bits 0,1
    8'b0010_1_0_0_0,  // SAMPLE: chain
    8'b1000_0_1_0_1,  // CLAMP: bypass, drive
    8'b1111_0_0_0_1,  // BYPASS
    8'b0101_0_0_0_1,  // unused -> bypass
    8'b1100_0_0_0_1   // unused -> bypass
  };

  logic tck = 1'b0;
  logic rst_ni = 1'b0;
  logic tms_i = 1'b1, tdi_i = 1'b0, bsr_so_i = 1'b0, sec_tdo_i = 1'b0;
  logic tdo_o, tdo_oe_o, bsr_capture_o, bsr_shift_o, bsr_update_o, bsr_drive_o;
  logic bsr_si_o, sec_sel_o;
  int   n_run = 0, n_fail = 0;

  always #2.5 tck = ~tck;

  jtag_handoff_tap #(.ID_VAL(ID_VAL)) u_jtag_handoff_tap (
    .tck_i(tck), .rst_ni(rst_ni), .tms_i(tms_i), .tdi_i(tdi_i),
    .tdo_o(tdo_o), .tdo_oe_o(tdo_oe_o),
    .bsr_capture_o(bsr_capture_o), .bsr_shift_o(bsr_shift_o),
    .bsr_update_o(bsr_update_o), .bsr_drive_o(bsr_drive_o),
    .bsr_si_o(bsr_si_o), .bsr_so_i(bsr_so_i),
    .sec_sel_o(sec_sel_o), .sec_tdo_i(sec_tdo_i)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic tms, input logic tdi);
    tms_i = tms;
    tdi_i = tdi;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic load_ir(input logic [3:0] code);  // from RTI, back to RTI
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) tick(i == 3, code[i]);
    tick(1, 0);
    tick(0, 0);
  endtask

  task automatic to_shdr();
    tick(1, 0); tick(0, 0); tick(0, 0);
  endtask

  task automatic dr_exit();  // Shift-DR -> RTI
    tick(1, 0); tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic [3:0]  irs;
    @(negedge tck); #1;
    // R1 reset state
    check("R1 oe", tdo_oe_o, 0);
    check("R1 sec", sec_sel_o, 0);
    check("R1 drive", bsr_drive_o, 0);
    rst_ni = 1'b1;
    tick(0, 0);

    // R5 identification read, R10 enable window
    to_shdr();
    check("R10 oe in shift", tdo_oe_o, 1);
    got = '0;
    for (int i = 0; i < 32; i++) begin
      got[i] = tdo_o;
      tick(i == 31, 0);
    end
    check("R5 idcode", got, ID_EXP);
    check("R10 oe after exit", tdo_oe_o, 0);
    tick(1, 0); tick(0, 0);

    // R3 capture pattern, R4 update timing (load EXTEST)
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    irs = '0;
    for (int i = 0; i < 4; i++) begin
      irs[i] = tdo_o;
      tick(i == 3, 1'b0);
    end
    check("R3 ir capture", irs, 4'b0001);
    check("R4 no change in exit1", bsr_drive_o, 0);
    tick(1, 0);
    check("R4 change at update", bsr_drive_o, 1);
    tick(0, 0);

    // R7/R8 strobes under EXTEST
    bsr_so_i = 1'b1;
    tick(1, 0); tick(0, 0);
    check("R7 capture", bsr_capture_o, 1);
    tick(0, 0);
    check("R7 shift", bsr_shift_o, 1);
    check("R7 capture low", bsr_capture_o, 0);
    check("R7 chain on tdo", tdo_o, 1);
    check("R8 no early update", bsr_update_o, 0);
    tick(1, 0);
    check("R7 shift low", bsr_shift_o, 0);
    tick(1, 0);
    check("R8 update high", bsr_update_o, 1);
    tick(0, 0);
    check("R8 update low", bsr_update_o, 0);
    bsr_so_i = 1'b0;

    // R6/R7/R9 vector table
    for (int v = 0; v < NV; v++) begin
      load_ir(VEC[v][7:4]);
      check("R9 drive", bsr_drive_o, VEC[v][2]);
      to_shdr();
      check("R7 shift sel", bsr_shift_o, VEC[v][3]);
      check("R6 first bit", tdo_o, VEC[v][1]);
      tick(0, 1);
      check("R6 second bit", tdo_o, VEC[v][0]);
      dr_exit();
    end

    // R2 five TMS high from Shift-DR with EXTEST
    load_ir(4'h0);
    to_shdr();
    for (int i = 0; i < 5; i++) tick(1, 0);
    check("R2 drive cleared", bsr_drive_o, 0);
    tick(0, 0);
    to_shdr();
    check("R2 idcode bit0", tdo_o, 1);
    check("R2 chain not selected", bsr_shift_o, 0);
    dr_exit();

    // R11 handoff
    load_ir(4'h3);
    check("R11 sel", sec_sel_o, 1);
    check("R11 oe", tdo_oe_o, 1);
    sec_tdo_i = 1'b1; #1;
    check("R11 tdo follows 1", tdo_o, 1);
    sec_tdo_i = 1'b0; #1;
    check("R11 tdo follows 0", tdo_o, 0);
    for (int i = 0; i < 6; i++) tick(1, 0);
    check("R11 survives tms reset", sec_sel_o, 1);
    tick(0, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    check("R11 no strobes",
          {bsr_capture_o, bsr_shift_o, bsr_update_o}, 3'b000);
    check("R11 still oe", tdo_oe_o, 1);
    rst_ni = 1'b0; #1;
    check("R1 reset ends handoff", sec_sel_o, 0);
    check("R1 reset oe", tdo_oe_o, 0);
    @(negedge tck); #1;
    rst_ni = 1'b1;
    tick(0, 0);
    to_shdr();
    check("R1 idcode reloaded", tdo_o, 1);
    dr_exit();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule